// File: doc/BRIEF.md
# Selective Wake Configuration Register Bank

This block is a byte-addressed register store for the wake-frame filter of a CAN wake controller. A host reads and writes it through a plain address, write-data and write-strobe port. The read data is combinational on the address. The bank keeps the filter identifier, the identifier mask, a combined mask/DLC byte, up to eight data bytes, a bit-rate byte and an error threshold. It drives all of these to the filter logic as decoded fields. It also shows a frame-error count supplied by the filter logic. It never stores or changes that count.

Two flags control whether a wake filter may act. The first is a configuration-valid flag, which the host sets last. It drops by itself when any filter setting inside the protected address window is rewritten, or when the filter logic signals a frame-error overflow. The second is a wake-enable bit in a control byte. A mode byte takes a device mode request. The bank reports selective wake as armed only when all of the following hold: the flag is set, wake is enabled, and a standby request was written while both were set.

Top module: `swk_cfg_bank`

## Requirements
- R1: Identifier bytes at 30h–33h, identifier mask bytes at 34h–37h, the mask/DLC byte at 38h and data bytes at 39h–40h are fully writable. Each reads back what was last written and appears on the matching decoded output, with byte k of a group at bits 8k+7:8k.
- R2: After reset, every filter byte reads 00h, the threshold reads 1Fh, the control byte reads 04h, the mode field is 0, and both configuration-valid and armed are 0.
- R3: At 47h only bit 7 is stored; it is the configuration-valid flag. A read returns the flag in bit 7 with bits 6:0 zero.
- R4: A write to any address from 30h through 44h, including the unmapped 41h–43h, or to 46h, clears the configuration-valid flag on the next edge. A write to any other address leaves the flag unchanged.
- R5: A frame-error overflow pulse clears the configuration-valid flag. It wins over a write that would set the flag in the same cycle.
- R6: A read of 45h returns the frame-error count input. A write to 45h changes no stored byte and leaves the flag unchanged.
- R7: The threshold at 46h takes any value from 00h to FFh and drives the threshold output.
- R8: At 44h, bit 7 is FD-passive, bits 6:4 are the nominal rate and bits 3:2 are the FD data rate, each on its own output. Bits 1:0 read as zero.
- R9: The control byte at 10h is fully writable, and its bit 7 is the wake-enable output.
- R10: The mode byte at 0Ch stores a mode field in bits 2:0, where 100b requests standby. Bits 7:3 read as zero.
- R11: Armed becomes 1 only after a write of standby to the mode byte while enable and flag are both set. It falls when either of them clears or when a non-standby mode is written.
- R12: Reads of every unmapped address return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 8 | Byte address |
| host_wdata | input | 8 | Write data |
| host_we | input | 1 | Write strobe, one byte per cycle |
| host_rdata | output | 8 | Read data for host_addr, combinational |
| err_count_in | input | 8 | Frame-error count from the filter logic |
| err_ovf_evt | input | 1 | One-cycle frame-error overflow pulse |
| flt_id | output | 32 | Identifier bytes |
| flt_mask | output | 32 | Identifier mask bytes |
| flt_dlc_mask | output | 8 | Mask/DLC byte |
| flt_data | output | 64 | Data bytes |
| fd_passive | output | 1 | FD-passive select |
| nom_rate | output | 3 | Nominal bit-rate select |
| fd_rate | output | 2 | FD data-rate select |
| err_thresh | output | 8 | Frame-error threshold |
| cfg_valid | output | 1 | Configuration-valid flag |
| wake_en | output | 1 | Selective wake enable |
| wake_armed | output | 1 | Selective wake armed |

## Verification
The bench uses the default parameters: four identifier bytes, four mask bytes, eight data bytes and the configuration group at 44h. With these values the protected window runs from 30h to 44h and includes the unmapped gap 41h–43h, so window clears from holes in the map are exercised. The defaults also place 45h just outside the window and 47h beside it, so both edges of the window are tested. Directed sequences cover the arm, disarm and overflow-priority orderings. A long random phase then mixes writes across 00h–7Fh with overflow pulses, and a full address sweep at each end covers the unmapped reads.

// File: rtl/swk_pkg.sv
package swk_pkg;

    // One-hot-ish address selection produced by the decoder
    typedef struct packed {
        logic       id;
        logic       mask;
        logic       dlc;
        logic       data;
        logic       cfg1;
        logic       cnt;
        logic       thr;
        logic       cfg4;
        logic       ctrl;
        logic       mode;
        logic       window;
        logic [7:0] off;
    } swk_sel_t;

endpackage

// File: rtl/swk_addr_dec.sv
module swk_addr_dec
    import swk_pkg::*;
#(
    parameter logic [7:0] ID_BASE    = 8'h30,
    parameter int         ID_BYTES   = 4,
    parameter int         MASK_BYTES = 4,
    parameter int         DATA_BYTES = 8,
    parameter logic [7:0] CFG_BASE   = 8'h44,
    parameter logic [7:0] CTRL_ADDR  = 8'h10,
    parameter logic [7:0] MODE_ADDR  = 8'h0C
) (
    input  logic [7:0] addr,
    output swk_sel_t   sel
);
    localparam logic [7:0] MASK_BASE = ID_BASE + 8'(ID_BYTES);
    localparam logic [7:0] DLC_ADDR  = MASK_BASE + 8'(MASK_BYTES);
    localparam logic [7:0] DATA_BASE = DLC_ADDR + 8'd1;
    localparam logic [7:0] CNT_ADDR  = CFG_BASE + 8'd1;
    localparam logic [7:0] THR_ADDR  = CFG_BASE + 8'd2;
    localparam logic [7:0] CFG4_ADDR = CFG_BASE + 8'd3;

    always_comb begin
        sel        = '0;
        sel.id     = (addr >= ID_BASE)   && (addr < MASK_BASE);
        sel.mask   = (addr >= MASK_BASE) && (addr < DLC_ADDR);
        sel.dlc    = (addr == DLC_ADDR);
        sel.data   = (addr >= DATA_BASE) && (addr < DATA_BASE + 8'(DATA_BYTES));
        sel.cfg1   = (addr == CFG_BASE);
        sel.cnt    = (addr == CNT_ADDR);
        sel.thr    = (addr == THR_ADDR);
        sel.cfg4   = (addr == CFG4_ADDR);
        sel.ctrl   = (addr == CTRL_ADDR);
        sel.mode   = (addr == MODE_ADDR);
        // protected window: filter bytes up to the rate byte, plus threshold
        sel.window = ((addr >= ID_BASE) && (addr <= CFG_BASE)) || sel.thr;
        if (sel.id)        sel.off = addr - ID_BASE;
        else if (sel.mask) sel.off = addr - MASK_BASE;
        else if (sel.data) sel.off = addr - DATA_BASE;
        else               sel.off = '0;
    end
endmodule

// File: rtl/swk_filter_regs.sv
module swk_filter_regs #(
    parameter int         ID_BYTES   = 4,
    parameter int         MASK_BYTES = 4,
    parameter int         DATA_BYTES = 8,
    parameter logic [7:0] THR_RESET  = 8'd31
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [7:0]              wdata,
    input  logic                    hit_id,
    input  logic                    hit_mask,
    input  logic                    hit_dlc,
    input  logic                    hit_data,
    input  logic                    hit_cfg1,
    input  logic                    hit_thr,
    input  logic                    hit_cnt,
    input  logic [7:0]              off,
    output logic [ID_BYTES*8-1:0]   id_o,
    output logic [MASK_BYTES*8-1:0] mask_o,
    output logic [7:0]              dlc_o,
    output logic [DATA_BYTES*8-1:0] data_o,
    output logic [5:0]              cfg1_o,
    output logic [7:0]              thr_o
);
    typedef struct packed {
        logic [ID_BYTES-1:0][7:0]   id;
        logic [MASK_BYTES-1:0][7:0] mask;
        logic [7:0]                 dlc;
        logic [DATA_BYTES-1:0][7:0] data;
        logic [5:0]                 cfg1;
        logic [7:0]                 thr;
    } fregs_t;

    fregs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            for (int i = 0; i < ID_BYTES; i++)
                if (hit_id && off == 8'(i)) st_d.id[i] = wdata;
            for (int i = 0; i < MASK_BYTES; i++)
                if (hit_mask && off == 8'(i)) st_d.mask[i] = wdata;
            for (int i = 0; i < DATA_BYTES; i++)
                if (hit_data && off == 8'(i)) st_d.data[i] = wdata;
            if (hit_dlc)  st_d.dlc  = wdata;
            if (hit_cfg1) st_d.cfg1 = wdata[7:2];
            if (hit_thr)  st_d.thr  = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.thr <= THR_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign id_o   = st_q.id;
    assign mask_o = st_q.mask;
    assign dlc_o  = st_q.dlc;
    assign data_o = st_q.data;
    assign cfg1_o = st_q.cfg1;
    assign thr_o  = st_q.thr;

    // counter byte is read-only: a write there leaves every stored byte
    assert_cnt_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (we && hit_cnt) |=> $stable(st_q));

    assert_thr_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && hit_thr) |=> (thr_o == $past(wdata)));
endmodule

// File: rtl/swk_arm_ctrl.sv
module swk_arm_ctrl #(
    parameter logic [7:0] CTRL_RESET = 8'h04,
    parameter logic [2:0] STBY_CODE  = 3'b100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    input  logic       hit_ctrl,
    input  logic       hit_mode,
    input  logic       hit_cfg4,
    input  logic       in_window,
    input  logic       ovf_evt,
    output logic [7:0] ctrl_o,
    output logic [2:0] mode_o,
    output logic       cfg_o,
    output logic       armed_o
);
    typedef struct packed {
        logic [7:0] ctrl;
        logic [2:0] mode;
        logic       cfg;
        logic       armed;
    } arm_t;

    arm_t st_d, st_q;
    logic keep;

    always_comb begin
        st_d = st_q;
        if (we && hit_ctrl) st_d.ctrl = wdata;
        if (we && hit_mode) st_d.mode = wdata[2:0];
        // flag: overflow dominates, then explicit load, then window disturb
        if (ovf_evt)                st_d.cfg = 1'b0;
        else if (we && hit_cfg4)    st_d.cfg = wdata[7];
        else if (we && in_window)   st_d.cfg = 1'b0;
        keep = st_d.cfg && st_d.ctrl[7];
        if (!keep)                  st_d.armed = 1'b0;
        else if (we && hit_mode)    st_d.armed = (wdata[2:0] == STBY_CODE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ctrl <= CTRL_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o  = st_q.ctrl;
    assign mode_o  = st_q.mode;
    assign cfg_o   = st_q.cfg;
    assign armed_o = st_q.armed;

    assert_cfg_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && hit_cfg4 && !ovf_evt) |=> (cfg_o == $past(wdata[7])));

    assert_win_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && in_window) |=> !cfg_o);

    assert_ovf_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> !cfg_o);

    assert_arm_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed_o) |-> $past(we && hit_mode && (wdata[2:0] == STBY_CODE)));
endmodule

// File: rtl/swk_cfg_bank.sv
module swk_cfg_bank
    import swk_pkg::*;
#(
    parameter logic [7:0] ID_BASE    = 8'h30,
    parameter int         ID_BYTES   = 4,
    parameter int         MASK_BYTES = 4,
    parameter int         DATA_BYTES = 8,
    parameter logic [7:0] CFG_BASE   = 8'h44,
    parameter logic [7:0] CTRL_ADDR  = 8'h10,
    parameter logic [7:0] MODE_ADDR  = 8'h0C,
    parameter logic [7:0] CTRL_RESET = 8'h04,
    parameter logic [7:0] THR_RESET  = 8'd31,
    parameter logic [2:0] STBY_CODE  = 3'b100
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [7:0]              host_addr,
    input  logic [7:0]              host_wdata,
    input  logic                    host_we,
    output logic [7:0]              host_rdata,
    input  logic [7:0]              err_count_in,
    input  logic                    err_ovf_evt,
    output logic [ID_BYTES*8-1:0]   flt_id,
    output logic [MASK_BYTES*8-1:0] flt_mask,
    output logic [7:0]              flt_dlc_mask,
    output logic [DATA_BYTES*8-1:0] flt_data,
    output logic                    fd_passive,
    output logic [2:0]              nom_rate,
    output logic [1:0]              fd_rate,
    output logic [7:0]              err_thresh,
    output logic                    cfg_valid,
    output logic                    wake_en,
    output logic                    wake_armed
);
    swk_sel_t   sel;
    logic [5:0] cfg1_q;
    logic [7:0] ctrl_q;
    logic [2:0] mode_q;

    swk_addr_dec #(
        .ID_BASE(ID_BASE), .ID_BYTES(ID_BYTES), .MASK_BYTES(MASK_BYTES),
        .DATA_BYTES(DATA_BYTES), .CFG_BASE(CFG_BASE),
        .CTRL_ADDR(CTRL_ADDR), .MODE_ADDR(MODE_ADDR)
    ) u_dec (
        .addr (host_addr),
        .sel  (sel)
    );

    swk_filter_regs #(
        .ID_BYTES(ID_BYTES), .MASK_BYTES(MASK_BYTES),
        .DATA_BYTES(DATA_BYTES), .THR_RESET(THR_RESET)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (host_we),
        .wdata    (host_wdata),
        .hit_id   (sel.id),
        .hit_mask (sel.mask),
        .hit_dlc  (sel.dlc),
        .hit_data (sel.data),
        .hit_cfg1 (sel.cfg1),
        .hit_thr  (sel.thr),
        .hit_cnt  (sel.cnt),
        .off      (sel.off),
        .id_o     (flt_id),
        .mask_o   (flt_mask),
        .dlc_o    (flt_dlc_mask),
        .data_o   (flt_data),
        .cfg1_o   (cfg1_q),
        .thr_o    (err_thresh)
    );

    swk_arm_ctrl #(
        .CTRL_RESET(CTRL_RESET), .STBY_CODE(STBY_CODE)
    ) u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (host_we),
        .wdata     (host_wdata),
        .hit_ctrl  (sel.ctrl),
        .hit_mode  (sel.mode),
        .hit_cfg4  (sel.cfg4),
        .in_window (sel.window),
        .ovf_evt   (err_ovf_evt),
        .ctrl_o    (ctrl_q),
        .mode_o    (mode_q),
        .cfg_o     (cfg_valid),
        .armed_o   (wake_armed)
    );

    assign fd_passive = cfg1_q[5];
    assign nom_rate   = cfg1_q[4:2];
    assign fd_rate    = cfg1_q[1:0];
    assign wake_en    = ctrl_q[7];

    // read-back mux
    always_comb begin
        host_rdata = '0;
        for (int i = 0; i < ID_BYTES; i++)
            if (sel.id && sel.off == 8'(i)) host_rdata = flt_id[i*8 +: 8];
        for (int i = 0; i < MASK_BYTES; i++)
            if (sel.mask && sel.off == 8'(i)) host_rdata = flt_mask[i*8 +: 8];
        for (int i = 0; i < DATA_BYTES; i++)
            if (sel.data && sel.off == 8'(i)) host_rdata = flt_data[i*8 +: 8];
        if (sel.dlc)  host_rdata = flt_dlc_mask;
        if (sel.cfg1) host_rdata = {cfg1_q, 2'b00};
        if (sel.cnt)  host_rdata = err_count_in;
        if (sel.thr)  host_rdata = err_thresh;
        if (sel.cfg4) host_rdata = {cfg_valid, 7'b0};
        if (sel.ctrl) host_rdata = ctrl_q;
        if (sel.mode) host_rdata = {5'b0, mode_q};
    end

    // armed never outlives its conditions
    assert_armed_needs_cfg_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cfg_valid) || $fell(wake_en)) |-> !wake_armed);
endmodule

// File: tb/tb_swk_cfg_bank.sv
`timescale 1ns/1ps
module tb_swk_cfg_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_we = 1'b0;
    logic [7:0]  host_rdata;
    logic [7:0]  err_count_in = '0;
    logic        err_ovf_evt = 1'b0;
    logic [31:0] flt_id, flt_mask;
    logic [7:0]  flt_dlc_mask, err_thresh;
    logic [63:0] flt_data;
    logic        fd_passive, cfg_valid, wake_en, wake_armed;
    logic [2:0]  nom_rate;
    logic [1:0]  fd_rate;

    int n_cmp = 0;
    int n_bad = 0;

    // reference state
    logic [7:0] mem [256];
    logic       m_cfg;
    logic       m_armed;

    always #2 clk = ~clk;

    swk_cfg_bank dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_we(host_we), .host_rdata(host_rdata), .err_count_in(err_count_in),
        .err_ovf_evt(err_ovf_evt), .flt_id(flt_id), .flt_mask(flt_mask),
        .flt_dlc_mask(flt_dlc_mask), .flt_data(flt_data), .fd_passive(fd_passive),
        .nom_rate(nom_rate), .fd_rate(fd_rate), .err_thresh(err_thresh),
        .cfg_valid(cfg_valid), .wake_en(wake_en), .wake_armed(wake_armed)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic void model_reset();
        for (int a = 0; a < 256; a++) mem[a] = 8'h00;
        mem[8'h46] = 8'd31;
        mem[8'h10] = 8'h04;
        m_cfg = 1'b0;
        m_armed = 1'b0;
    endfunction

    function automatic logic [7:0] model_read(input logic [7:0] a);
        if (a >= 8'h30 && a <= 8'h40) return mem[a];
        case (a)
            8'h44: return mem[a] & 8'hFC;
            8'h45: return err_count_in;
            8'h46: return mem[a];
            8'h47: return {m_cfg, 7'b0};
            8'h10: return mem[a];
            8'h0C: return mem[a] & 8'h07;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string rtag(input logic [7:0] a);
        if (a >= 8'h30 && a <= 8'h40) return "R1";
        case (a)
            8'h44: return "R8";
            8'h45: return "R6";
            8'h46: return "R7";
            8'h47: return "R3";
            8'h10: return "R9";
            8'h0C: return "R10";
            default: return "R12";
        endcase
    endfunction

    // next state from the requirements, applied after each clock edge
    function automatic void model_step(input logic we, input logic [7:0] a,
                                       input logic [7:0] d, input logic ovf);
        logic wr_win, keep;
        wr_win = we && (((a >= 8'h30) && (a <= 8'h44)) || a == 8'h46);
        if (we && a != 8'h45 && a != 8'h47) mem[a] = d;
        if (ovf)                    m_cfg = 1'b0;
        else if (we && a == 8'h47)  m_cfg = d[7];
        else if (wr_win)            m_cfg = 1'b0;
        keep = m_cfg && mem[8'h10][7];
        if (!keep)                  m_armed = 1'b0;
        else if (we && a == 8'h0C)  m_armed = (d[2:0] == 3'b100);
    endfunction

    task automatic compare_all();
        logic [63:0] e_id, e_mask, e_data;
        for (int k = 0; k < 4; k++) e_id[k*8 +: 8] = mem[8'h30 + k];
        for (int k = 0; k < 4; k++) e_mask[k*8 +: 8] = mem[8'h34 + k];
        for (int k = 0; k < 8; k++) e_data[k*8 +: 8] = mem[8'h39 + k];
        chk(rtag(host_addr), host_rdata, model_read(host_addr));
        chk("R1 id", flt_id, e_id[31:0]);
        chk("R1 mask", flt_mask, e_mask[31:0]);
        chk("R1 dlc", flt_dlc_mask, mem[8'h38]);
        chk("R1 data", flt_data, e_data);
        chk("R8 fd", fd_passive, mem[8'h44][7]);
        chk("R8 nom", nom_rate, mem[8'h44][6:4]);
        chk("R8 fdr", fd_rate, mem[8'h44][3:2]);
        chk("R7 thr", err_thresh, mem[8'h46]);
        chk("R9 en", wake_en, mem[8'h10][7]);
        chk("R4_R5 cfg", cfg_valid, m_cfg);
        chk("R11 armed", wake_armed, m_armed);
    endtask

    task automatic step();
        @(posedge clk);
        #1 model_step(host_we, host_addr, host_wdata, err_ovf_evt);
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        step();
        host_we = 1'b0;
        step();
    endtask

    task automatic rd(input logic [7:0] a);
        host_we = 1'b0; host_addr = a;
        step();
    endtask

    task automatic pulse_ovf();
        err_ovf_evt = 1'b1;
        step();
        err_ovf_evt = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2: reset state
        host_addr = 8'h10;
        #0;
        chk("R2 ctrl", host_rdata, 8'h04);
        chk("R2 thr", err_thresh, 8'd31);
        chk("R2 cfg", cfg_valid, 1'b0);
        chk("R2 armed", wake_armed, 1'b0);
        chk("R2 id", flt_id, 32'h0);
        // R12 and reset values across the whole map
        err_count_in = 8'h5A;
        for (int a = 0; a < 256; a++) rd(8'(a));

        // R1, R7, R8: load the filter
        for (int a = 8'h30; a <= 8'h40; a++) wr(8'(a), 8'(a * 7 + 3));
        wr(8'h44, 8'hAB);          // R8: low bits must read zero
        wr(8'h46, 8'hFF);          // R7: top of range
        wr(8'h46, 8'h00);          // R7: bottom of range
        for (int a = 8'h30; a <= 8'h47; a++) rd(8'(a));

        // R3, R9, R10, R11: arm sequence
        wr(8'h47, 8'hFF);
        wr(8'h10, 8'h84);
        wr(8'h0C, 8'hFC);          // standby, reserved bits dropped
        rd(8'h0C);
        chk("R11 armed after standby", wake_armed, 1'b1);

        // R6: counter writes have no effect
        wr(8'h45, 8'h00);
        rd(8'h45);
        chk("R6 flag kept", cfg_valid, 1'b1);

        // R4: unmapped hole inside window clears
        wr(8'h42, 8'h11);
        chk("R4 hole clears", cfg_valid, 1'b0);
        chk("R11 disarm", wake_armed, 1'b0);

        // R11: re-setting the flag does not re-arm without a new request
        wr(8'h47, 8'h80);
        chk("R11 no auto arm", wake_armed, 1'b0);
        wr(8'h0C, 8'h04);
        chk("R11 rearm", wake_armed, 1'b1);
        wr(8'h0C, 8'h02);
        chk("R11 non-standby", wake_armed, 1'b0);
        wr(8'h0C, 8'h04);
        wr(8'h10, 8'h04);
        chk("R11 enable off", wake_armed, 1'b0);
        wr(8'h10, 8'h84);
        wr(8'h0C, 8'h04);

        // R5: overflow clears, and wins over a same-cycle set
        pulse_ovf();
        chk("R5 ovf clears", cfg_valid, 1'b0);
        host_we = 1'b1; host_addr = 8'h47; host_wdata = 8'h80; err_ovf_evt = 1'b1;
        step();
        host_we = 1'b0; err_ovf_evt = 1'b0;
        chk("R5 ovf priority", cfg_valid, 1'b0);

        // R4: window edges
        wr(8'h47, 8'h80);
        wr(8'h48, 8'h55);
        chk("R4 outside keeps", cfg_valid, 1'b1);
        wr(8'h46, 8'h1F);
        chk("R4 thr clears", cfg_valid, 1'b0);
        wr(8'h47, 8'h80);
        wr(8'h2F, 8'h55);
        chk("R4 below keeps", cfg_valid, 1'b1);
        wr(8'h44, 8'h20);
        chk("R4 top edge clears", cfg_valid, 1'b0);

        // mixed random traffic
        for (int n = 0; n < 3000; n++) begin
            int pick;
            pick = $urandom_range(0, 15);
            host_we = ($urandom_range(0, 3) != 0);
            if (pick == 0)      begin host_addr = 8'h0C; host_wdata = 8'($urandom_range(0,1) ? 4 : $urandom_range(0,255)); end
            else if (pick == 1) begin host_addr = 8'h47; host_wdata = 8'($urandom_range(0,255)); end
            else if (pick == 2) begin host_addr = 8'h10; host_wdata = 8'($urandom_range(0,1) ? 8'h84 : $urandom_range(0,255)); end
            else                begin host_addr = 8'($urandom_range(0,127)); host_wdata = 8'($urandom_range(0,255)); end
            err_ovf_evt = ($urandom_range(0, 40) == 0);
            err_count_in = 8'($urandom_range(0,255));
            step();
        end
        host_we = 1'b0; err_ovf_evt = 1'b0;
        for (int a = 0; a < 256; a++) rd(8'(a));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule